// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block selects the operating mode of a digital phase-locked loop used in network timing equipment. It runs a five-state machine with the modes reset, free-run, holdover, normal (locked) and automatic holdover. It moves between them under a two-bit mode-select code from the system and under status flags from the loop. Those flags are a reference-valid indication, a lock indication and a strobe that marks a change of the selected reference.

Two features set it apart. First, a guard stops the controller from entering normal mode while the reference is invalid, whatever code is applied. Second, the return from automatic holdover to normal can be configured. It either happens as soon as the reference comes back, or it also waits for a rising edge on a manual release input. The outputs tell the loop whether to track the reference or to hold its frequency frozen, and they flag lock.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rst_n_i` is low, `mode_o` reads 000 and `lock_o`, `track_en_o` and `freeze_en_o` are 0. On the first rising clock edge after release, `mode_o` becomes 001 (free-run), whatever the select code.
- R2: A select code of 10 on a rising edge moves the controller to free-run (001) from any state.
- R3: In free-run, a select code of 00 or 01 moves the controller to holdover (010) on the next edge.
- R4: In holdover, the controller moves to normal (011) when all of these hold: the code is 00, `ref_valid_i` is 1, `loop_lock_i` is 1 and `ref_chg_i` is 0. Otherwise it stays in holdover, for as long as that takes.
- R5: Normal mode is never entered on an edge where `ref_valid_i` is 0.
- R6: In normal mode with code 00, `ref_valid_i` at 0 moves the controller to automatic holdover (100).
- R7: In automatic holdover with code 00, `ref_chg_i` at 0 and `auto_rec_dis_i` at 0, `ref_valid_i` at 1 returns the controller to normal.
- R8: If `auto_rec_dis_i` is 1, that return also needs a rising edge on `hold_rel_i`, meaning it is 1 on this edge and was 0 on the previous edge. A level held high has no effect.
- R9: A `ref_chg_i` pulse in normal or automatic holdover, or code 01 in normal, sends the controller to holdover.
- R10: Code 11 is reserved. In any state other than reset it leaves the mode unchanged.
- R11: `lock_o` and `track_en_o` are 1 exactly in normal. `freeze_en_o` is 1 exactly in holdover and automatic holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Mode select: 00 normal, 01 holdover, 10 free-run, 11 reserved |
| ref_chg_i | input | 1 | Strobe: selected reference changed |
| ref_valid_i | input | 1 | Reference is usable |
| loop_lock_i | input | 1 | Loop reports phase lock |
| auto_rec_dis_i | input | 1 | 1: recovery from automatic holdover waits for manual release |
| hold_rel_i | input | 1 | Manual holdover release; acts on its rising edge |
| mode_o | output | 3 | Current mode: 000 reset, 001 free-run, 010 holdover, 011 normal, 100 automatic holdover |
| lock_o | output | 1 | Locked status flag |
| track_en_o | output | 1 | Loop tracks the reference |
| freeze_en_o | output | 1 | Loop holds a frozen frequency |

## Verification
The bench tries to force normal mode with the normal code applied while the reference is invalid and lock is reported. A design without the guard would show 011 there. With recovery disabled, it holds the manual release input high across the reference's return. A level-sensitive release would then return to normal early, and a design that ignores the release would stay in 100 for good. Further checks apply code 11 in normal with a failed reference and release reset under code 11. A wrong priority would show up as a mode change in either case. Random stimulus then mixes every code, strobe and reset against a bench model.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_RESET = 3'd0,
        MD_FREE  = 3'd1,
        MD_HOLD  = 3'd2,
        MD_NORM  = 3'd3,
        MD_AUTO  = 3'd4
    } mode_t;

    localparam logic [SEL_W-1:0] SEL_NORMAL = 2'b00;
    localparam logic [SEL_W-1:0] SEL_HOLD   = 2'b01;
    localparam logic [SEL_W-1:0] SEL_FREE   = 2'b10;
    localparam logic [SEL_W-1:0] SEL_RSVD   = 2'b11;

endpackage

// File: rtl/dmc_rise_det.sv
module dmc_rise_det #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } det_t;

    det_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cur_q <= '0;
        else          cur_q <= nxt_d;
    end

    assign rise_o = sig_i & ~cur_q.prev;

endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
    import dpll_mode_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             chg_i,
    input  logic             ref_ok_i,
    input  logic             lock_i,
    input  logic             rec_dis_i,
    input  logic             rel_rise_i,
    output mode_t            state_o
);

    typedef struct packed {
        mode_t state;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic acq_ok, rec_ok;

    // holdover may only finish acquisition with a usable, locked reference
    assign acq_ok = (sel_i == SEL_NORMAL) && ref_ok_i && lock_i && !chg_i;
    // recovery from automatic holdover: reference back, optional manual release
    assign rec_ok = (sel_i == SEL_NORMAL) && ref_ok_i && (!rec_dis_i || rel_rise_i);

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.state == MD_RESET) begin
            nxt_d.state = MD_FREE;
        end else if (sel_i == SEL_FREE) begin
            nxt_d.state = MD_FREE;
        end else if (sel_i == SEL_RSVD) begin
            nxt_d.state = cur_q.state;
        end else begin
            unique case (cur_q.state)
                MD_FREE: nxt_d.state = MD_HOLD;
                MD_HOLD: if (acq_ok) nxt_d.state = MD_NORM;
                MD_NORM: begin
                    if (chg_i || sel_i == SEL_HOLD) nxt_d.state = MD_HOLD;
                    else if (!ref_ok_i)              nxt_d.state = MD_AUTO;
                end
                MD_AUTO: begin
                    if (chg_i)       nxt_d.state = MD_HOLD;
                    else if (rec_ok) nxt_d.state = MD_NORM;
                end
                default: nxt_d.state = MD_FREE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cur_q <= '{state: MD_RESET};
        else          cur_q <= nxt_d;
    end

    assign state_o = cur_q.state;

endmodule

// File: rtl/dmc_out_map.sv
module dmc_out_map
    import dpll_mode_pkg::*;
(
    input  mode_t              state_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic               lock_o,
    output logic               track_en_o,
    output logic               freeze_en_o
);

    always_comb begin
        mode_o      = state_i;
        lock_o      = 1'b0;
        track_en_o  = 1'b0;
        freeze_en_o = 1'b0;
        case (state_i)
            MD_NORM: begin
                lock_o     = 1'b1;
                track_en_o = 1'b1;
            end
            MD_HOLD, MD_AUTO: freeze_en_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [SEL_W-1:0]  mode_sel_i,
    input  logic              ref_chg_i,
    input  logic              ref_valid_i,
    input  logic              loop_lock_i,
    input  logic              auto_rec_dis_i,
    input  logic              hold_rel_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              lock_o,
    output logic              track_en_o,
    output logic              freeze_en_o
);

    logic  rel_rise;
    mode_t state;

    dmc_rise_det #(.W(1)) u_rel (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .sig_i   (hold_rel_i),
        .rise_o  (rel_rise)
    );

    dmc_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sel_i      (mode_sel_i),
        .chg_i      (ref_chg_i),
        .ref_ok_i   (ref_valid_i),
        .lock_i     (loop_lock_i),
        .rec_dis_i  (auto_rec_dis_i),
        .rel_rise_i (rel_rise),
        .state_o    (state)
    );

    dmc_out_map u_out (
        .state_i     (state),
        .mode_o      (mode_o),
        .lock_o      (lock_o),
        .track_en_o  (track_en_o),
        .freeze_en_o (freeze_en_o)
    );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
    import dpll_mode_pkg::*;
(
    input logic              clk_i,
    input logic              rst_n_i,
    input logic [SEL_W-1:0]  mode_sel_i,
    input logic              ref_valid_i,
    input logic              auto_rec_dis_i,
    input logic              hold_rel_i,
    input logic [MODE_W-1:0] mode_o,
    input logic              lock_o,
    input logic              freeze_en_o
);

    // R2
    force_free_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_sel_i == SEL_FREE) |=> (mode_o == MD_FREE));

    // R5
    guard_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_sel_i != SEL_FREE && mode_o != MD_NORM) |=>
            (mode_o != MD_NORM || $past(ref_valid_i)));

    // R8
    held_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_o == MD_AUTO && auto_rec_dis_i && !hold_rel_i) |=> (mode_o != MD_NORM));

    // R10
    reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_sel_i == SEL_RSVD && mode_o != MD_RESET) |=> $stable(mode_o));

    // R11
    lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(lock_o) |-> ($past(mode_o) == MD_HOLD || $past(mode_o) == MD_AUTO));

    // R11
    flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({lock_o, freeze_en_o}));

endmodule

bind dpll_mode_ctrl dmc_checker u_chk (
    .clk_i          (clk_i),
    .rst_n_i        (rst_n_i),
    .mode_sel_i     (mode_sel_i),
    .ref_valid_i    (ref_valid_i),
    .auto_rec_dis_i (auto_rec_dis_i),
    .hold_rel_i     (hold_rel_i),
    .mode_o         (mode_o),
    .lock_o         (lock_o),
    .freeze_en_o    (freeze_en_o)
);

// File: tb/dpll_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dpll_mode_ctrl_tb;

    localparam logic [2:0] E_RST = 3'd0, E_FREE = 3'd1, E_HOLD = 3'd2,
                           E_NORM = 3'd3, E_AUTO = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ms = 2'b11;
    logic       chg = 0, rv = 0, lk = 0, dis = 0, rel = 0;
    logic [2:0] mode;
    logic       lock, track, freeze;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] exp_st = E_RST;
    logic       prev_rel = 1'b0;
    bit         done = 0;

    always #5 clk = ~clk;

    dpll_mode_ctrl u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .mode_sel_i(ms), .ref_chg_i(chg),
        .ref_valid_i(rv), .loop_lock_i(lk), .auto_rec_dis_i(dis),
        .hold_rel_i(rel), .mode_o(mode), .lock_o(lock),
        .track_en_o(track), .freeze_en_o(freeze)
    );

    function automatic logic [2:0] model_next(input logic [2:0] s, input logic [1:0] m,
            input logic c, input logic v, input logic l, input logic d, input logic rr);
        if (s == E_RST)   return E_FREE;
        if (m == 2'b10)   return E_FREE;
        if (m == 2'b11)   return s;
        case (s)
            E_FREE: return E_HOLD;
            E_HOLD: return (m == 2'b00 && v && l && !c) ? E_NORM : E_HOLD;
            E_NORM: begin
                if (c || m == 2'b01) return E_HOLD;
                if (!v)              return E_AUTO;
                return E_NORM;
            end
            E_AUTO: begin
                if (c) return E_HOLD;
                if (m == 2'b00 && v && (!d || rr)) return E_NORM;
                return E_AUTO;
            end
            default: return E_FREE;
        endcase
    endfunction

    function automatic string rnd_tag(input logic [2:0] s, input logic [1:0] m);
        if (s == E_RST)   return "R1";
        if (m == 2'b10)   return "R2";
        if (m == 2'b11)   return "R10";
        case (s)
            E_FREE:  return "R3";
            E_HOLD:  return "R4";
            E_NORM:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_out(input string tag);
        logic el, ef;
        el = (exp_st == E_NORM);
        ef = (exp_st == E_HOLD) || (exp_st == E_AUTO);
        n_chk++;
        if (mode !== exp_st || lock !== el || track !== el || freeze !== ef) begin
            n_fail++;
            $display("FAIL %s: mode=%0d lock=%0b track=%0b freeze=%0b expected mode=%0d lock=%0b track=%0b freeze=%0b",
                     tag, mode, lock, track, freeze, exp_st, el, el, ef);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] m, input logic c, input logic v,
                        input logic l, input logic d, input logic e, input string tag);
        logic rr;
        @(negedge clk);
        rst_n = r; ms = m; chg = c; rv = v; lk = l; dis = d; rel = e;
        @(posedge clk);
        #1;
        if (!r) begin
            exp_st   = E_RST;
            prev_rel = 1'b0;
        end else begin
            rr       = e && !prev_rel;
            exp_st   = model_next(exp_st, m, c, v, l, d, rr);
            prev_rel = e;
        end
        check_out(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        // R1 reset state, then free-run even under the reserved code
        step(0, 2'b11, 0, 0, 0, 0, 0, "R1");
        step(0, 2'b11, 0, 0, 0, 0, 0, "R1");
        step(1, 2'b11, 0, 0, 0, 0, 0, "R1");
        // R10 reserved code holds free-run
        repeat (3) step(1, 2'b11, 0, 0, 0, 0, 0, "R10");
        // R3 leave free-run; R4/R5 hold with no reference despite lock
        step(1, 2'b00, 0, 0, 1, 0, 0, "R3");
        repeat (5) step(1, 2'b00, 0, 0, 1, 0, 0, "R5");
        // R4 reference but no lock: stay
        repeat (3) step(1, 2'b00, 0, 1, 0, 0, 0, "R4");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R4");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R11");
        // R9 manual holdover, then back
        step(1, 2'b01, 0, 1, 1, 0, 0, "R9");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R4");
        // R9 reference change
        step(1, 2'b00, 1, 1, 1, 0, 0, "R9");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R4");
        // R6 reference fails, R7 automatic recovery
        step(1, 2'b00, 0, 0, 1, 0, 0, "R6");
        step(1, 2'b00, 0, 0, 1, 0, 0, "R6");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R7");
        // R8 manual release: level held high has no effect
        step(1, 2'b00, 0, 1, 1, 1, 1, "R8");
        step(1, 2'b00, 0, 0, 1, 1, 1, "R6");
        repeat (3) step(1, 2'b00, 0, 1, 1, 1, 1, "R8");
        step(1, 2'b00, 0, 1, 1, 1, 0, "R8");
        step(1, 2'b00, 0, 1, 1, 1, 1, "R8");
        // R10 reserved code in normal with failed reference
        repeat (2) step(1, 2'b11, 0, 0, 1, 0, 0, "R10");
        // R2 forced free-run from normal and from automatic holdover
        step(1, 2'b10, 0, 1, 1, 0, 0, "R2");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R3");
        step(1, 2'b00, 0, 1, 1, 0, 0, "R4");
        step(1, 2'b00, 0, 0, 1, 1, 0, "R6");
        step(1, 2'b10, 0, 0, 1, 1, 0, "R2");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic       r, c, v, l, d, e;
            logic [1:0] m;
            int         p;
            string      tg;
            r = ($urandom_range(99) != 0);
            p = $urandom_range(99);
            m = (p < 55) ? 2'b00 : (p < 75) ? 2'b01 : (p < 83) ? 2'b10 : 2'b11;
            c = ($urandom_range(19) == 0);
            v = (rv ? ($urandom_range(9) != 0) : ($urandom_range(3) == 0));
            l = ($urandom_range(9) < 7);
            d = ($urandom_range(1) == 1);
            e = ($urandom_range(3) == 0);
            tg = r ? rnd_tag(exp_st, m) : "R1";
            step(r, m, c, v, l, d, e, tg);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule